// File: doc/BRIEF.md
# Binary n-Cube Node Router

This block is the routing logic for a single node of a binary n-cube, a network of 2^n nodes in which each node's address differs from each of its n neighbours' addresses in exactly one bit. The node's own address is a fixed parameter. Messages arrive from the local processor and from the n neighbour links. Each message carries a destination address, a hop count and a payload, and each input uses a valid/ready handshake.

For every input message the router takes the XOR of the node address and the destination. A zero result means the message is for this node, and it goes to the local delivery output with its hop count unchanged. Otherwise the message leaves on the link given by the lowest set bit of the XOR, with its hop count raised by one. Each hop therefore corrects exactly one dimension, in ascending dimension order, and a route is between one and n links long.

Each output has a one-entry register stage. When several inputs want the same output in the same cycle, a fixed priority picks one: the lowest link index wins and the local processor input comes last.

Port index d, for d < n, is the link across dimension d. Port index n is the local processor, both on the receive side and on the transmit side.

Top module: `hcr_node_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every transmit valid is low.
- R2: A message whose destination equals the node address appears on transmit port n (local delivery) with its hop count, destination and payload unchanged.
- R3: A message whose destination differs from the node address appears on transmit link d, where d is the lowest bit position at which destination and node address differ.
- R4: A message forwarded on a link leaves with its hop count one higher than on arrival. No transmit hop count ever exceeds n.
- R5: Destination and payload are carried through to the chosen output unchanged.
- R6: When several valid inputs target the same output in one cycle, only the lowest-indexed one sees receive ready high. The local input (index n) has the lowest priority.
- R7: A transmit port that is valid while its ready is low keeps valid, destination, hop count and payload stable, and accepts no new message for that port.
- R8: A message accepted at a clock edge (receive valid and ready both high) is presented on its output right after that same edge.
- R9: Inputs that target different outputs are accepted in the same cycle.
- R10: Receive ready is never high on an input whose receive valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | DIM_N+1 | Per input port: a message is offered |
| rx_ready | output | DIM_N+1 | Per input port: the offered message is taken this cycle |
| rx_dst | input | (DIM_N+1)*DIM_N | Destination address per input port, packed by port index |
| rx_hops | input | (DIM_N+1)*HOP_W | Hop count per input port |
| rx_data | input | (DIM_N+1)*PAY_W | Payload per input port |
| tx_valid | output | DIM_N+1 | Per output port: a message is presented |
| tx_ready | input | DIM_N+1 | Per output port: the receiver takes the message |
| tx_dst | output | (DIM_N+1)*DIM_N | Destination address per output port |
| tx_hops | output | (DIM_N+1)*HOP_W | Hop count per output port |
| tx_data | output | (DIM_N+1)*PAY_W | Payload per output port |

## Verification
The bound checker watches properties that must hold in every cycle. A message on link d must still differ from the node address at bit d and agree with it at every lower bit. The local output may carry only this node's own address. Hop counts stay at or below n, stalled outputs hold steady, ready never rises without valid, and a self-addressed message that is accepted shows up on the local output one cycle later. Who wins a contention, the exact hop increment, and payload integrity all depend on the particular mix of inputs. Only the bench's reference model can judge those, by replaying directed contention and stall cases and a long randomized run with back-pressure.

// File: rtl/hcr_pkg.sv
// Package for the cube node router: shared helper functions.
// Assumes address vectors are no wider than 32 bits.
package hcr_pkg;

    // Index of the lowest set bit of v; returns 32 when v is zero.
    function automatic int unsigned first_one(input logic [31:0] v);
        int unsigned idx;
        idx = 32;
        for (int b = 31; b >= 0; b--) begin
            if (v[b]) idx = b;
        end
        return idx;
    endfunction

endpackage

// File: rtl/hcr_route_calc.sv
// Route calculation for one input port.
// Compares the destination with the fixed node address and produces a
// one-hot target: bit d (d < DIM_N) for link d, bit DIM_N for local delivery.
// Assumes DIM_N <= 31.
module hcr_route_calc
    import hcr_pkg::*;
#(
    parameter int          DIM_N     = 3,
    parameter int unsigned NODE_ADDR = 0
) (
    input  logic [DIM_N-1:0] dst,
    output logic [DIM_N:0]   target
);
    localparam logic [DIM_N-1:0] MY_ADDR = DIM_N'(NODE_ADDR);

    logic [DIM_N-1:0] diff;
    int unsigned      pick;

    // Differing dimensions between here and the destination.
    assign diff = dst ^ MY_ADDR;

    // Lowest differing dimension, or local delivery when none differs.
    always_comb begin
        target = '0;
        pick   = first_one(32'(diff));
        if (diff == '0) begin
            target[DIM_N] = 1'b1;
        end else begin
            for (int d = 0; d < DIM_N; d++) begin
                if (pick == d) target[d] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hcr_out_arb.sv
// Fixed-priority selector for one output port.
// Picks the lowest-indexed requesting input and steers its fields.
// The local input sits at the highest index and so loses every tie.
// BUMP_HOP adds one to the hop count (used on link outputs only).
module hcr_out_arb #(
    parameter int PORTS    = 4,
    parameter int DST_W    = 3,
    parameter int HOP_W    = 2,
    parameter int PAY_W    = 8,
    parameter bit BUMP_HOP = 1'b1
) (
    input  logic [PORTS-1:0]       req,
    input  logic [PORTS*DST_W-1:0] dst_all,
    input  logic [PORTS*HOP_W-1:0] hops_all,
    input  logic [PORTS*PAY_W-1:0] data_all,
    output logic [PORTS-1:0]       grant,
    output logic                   any,
    output logic [DST_W-1:0]       dst_sel,
    output logic [HOP_W-1:0]       hops_sel,
    output logic [PAY_W-1:0]       data_sel
);
    logic [HOP_W-1:0] hops_raw;

    // Grant the first requester in index order.
    always_comb begin
        grant = '0;
        for (int i = 0; i < PORTS; i++) begin
            if (req[i] && (grant == '0)) grant[i] = 1'b1;
        end
    end

    assign any = |req;

    // AND-OR multiplexer driven by the one-hot grant.
    always_comb begin
        dst_sel  = '0;
        hops_raw = '0;
        data_sel = '0;
        for (int i = 0; i < PORTS; i++) begin
            dst_sel  |= dst_all[i*DST_W +: DST_W]  & {DST_W{grant[i]}};
            hops_raw |= hops_all[i*HOP_W +: HOP_W] & {HOP_W{grant[i]}};
            data_sel |= data_all[i*PAY_W +: PAY_W] & {PAY_W{grant[i]}};
        end
    end

    // Hop update: links count one more hop, local delivery keeps it.
    generate
        if (BUMP_HOP) begin : g_bump
            assign hops_sel = hops_raw + HOP_W'(1);
        end else begin : g_keep
            assign hops_sel = hops_raw;
        end
    endgenerate

endmodule

// File: rtl/hcr_out_stage.sv
// One-entry output register with valid/ready handshake.
// Loads whenever it is empty or its content leaves in the same cycle,
// giving one message per cycle of throughput and one cycle of latency.
module hcr_out_stage #(
    parameter int DST_W = 3,
    parameter int HOP_W = 2,
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DST_W-1:0] in_dst,
    input  logic [HOP_W-1:0] in_hops,
    input  logic [PAY_W-1:0] in_data,
    output logic             can_load,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DST_W-1:0] out_dst,
    output logic [HOP_W-1:0] out_hops,
    output logic [PAY_W-1:0] out_data
);
    // Space exists when empty or when the held message drains now.
    assign can_load = !out_valid || out_ready;

    // Occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (can_load) out_valid <= in_valid;
    end

    // Message fields, captured only when a new message is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dst  <= '0;
            out_hops <= '0;
            out_data <= '0;
        end else if (can_load && in_valid) begin
            out_dst  <= in_dst;
            out_hops <= in_hops;
            out_data <= in_data;
        end
    end

endmodule

// File: rtl/hcr_node_router.sv
// Router for one node of a binary n-cube.
// Port index d < DIM_N is the link across dimension d; index DIM_N is the
// local processor (receive side) or local delivery (transmit side).
// Assumes senders hold a message until it is accepted and that arriving
// hop counts are below DIM_N when the message still needs forwarding.
module hcr_node_router #(
    parameter int          DIM_N     = 3,
    parameter int unsigned NODE_ADDR = 5,
    parameter int          PAY_W     = 8,
    parameter int          HOP_W     = $clog2(DIM_N + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DIM_N:0]                rx_valid,
    output logic [DIM_N:0]                rx_ready,
    input  logic [(DIM_N+1)*DIM_N-1:0]    rx_dst,
    input  logic [(DIM_N+1)*HOP_W-1:0]    rx_hops,
    input  logic [(DIM_N+1)*PAY_W-1:0]    rx_data,
    output logic [DIM_N:0]                tx_valid,
    input  logic [DIM_N:0]                tx_ready,
    output logic [(DIM_N+1)*DIM_N-1:0]    tx_dst,
    output logic [(DIM_N+1)*HOP_W-1:0]    tx_hops,
    output logic [(DIM_N+1)*PAY_W-1:0]    tx_data
);
    localparam int PORTS = DIM_N + 1;

    logic [PORTS-1:0] target   [PORTS];   // per input: chosen output
    logic [PORTS-1:0] out_req  [PORTS];   // per output: requesting inputs
    logic [PORTS-1:0] grant    [PORTS];   // per output: winning input
    logic [PORTS-1:0] can_load;
    logic [PORTS-1:0] win_any;
    logic [DIM_N-1:0] win_dst  [PORTS];
    logic [HOP_W-1:0] win_hops [PORTS];
    logic [PAY_W-1:0] win_data [PORTS];

    // One route calculator per input port.
    generate
        for (genvar i = 0; i < PORTS; i++) begin : g_route
            hcr_route_calc #(
                .DIM_N     (DIM_N),
                .NODE_ADDR (NODE_ADDR)
            ) route_i (
                .dst    (rx_dst[i*DIM_N +: DIM_N]),
                .target (target[i])
            );
        end
    endgenerate

    // Transpose targets into per-output request vectors.
    always_comb begin
        for (int o = 0; o < PORTS; o++) begin
            for (int i = 0; i < PORTS; i++) begin
                out_req[o][i] = target[i][o] & rx_valid[i];
            end
        end
    end

    // One selector and one register stage per output port.
    generate
        for (genvar o = 0; o < PORTS; o++) begin : g_out
            hcr_out_arb #(
                .PORTS    (PORTS),
                .DST_W    (DIM_N),
                .HOP_W    (HOP_W),
                .PAY_W    (PAY_W),
                .BUMP_HOP (o < DIM_N)
            ) arb_i (
                .req      (out_req[o]),
                .dst_all  (rx_dst),
                .hops_all (rx_hops),
                .data_all (rx_data),
                .grant    (grant[o]),
                .any      (win_any[o]),
                .dst_sel  (win_dst[o]),
                .hops_sel (win_hops[o]),
                .data_sel (win_data[o])
            );

            hcr_out_stage #(
                .DST_W (DIM_N),
                .HOP_W (HOP_W),
                .PAY_W (PAY_W)
            ) stage_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (win_any[o]),
                .in_dst    (win_dst[o]),
                .in_hops   (win_hops[o]),
                .in_data   (win_data[o]),
                .can_load  (can_load[o]),
                .out_valid (tx_valid[o]),
                .out_ready (tx_ready[o]),
                .out_dst   (tx_dst[o*DIM_N +: DIM_N]),
                .out_hops  (tx_hops[o*HOP_W +: HOP_W]),
                .out_data  (tx_data[o*PAY_W +: PAY_W])
            );
        end
    endgenerate

    // An input is taken when it wins its output and that output has space.
    always_comb begin
        rx_ready = '0;
        for (int i = 0; i < PORTS; i++) begin
            for (int o = 0; o < PORTS; o++) begin
                rx_ready[i] = rx_ready[i] | (grant[o][i] & can_load[o]);
            end
        end
    end

endmodule

// File: rtl/hcr_node_router_chk.sv
// Protocol and routing checker for hcr_node_router, attached by bind.
// Observes only the router's ports.
module hcr_node_router_chk #(
    parameter int          DIM_N     = 3,
    parameter int unsigned NODE_ADDR = 5,
    parameter int          PAY_W     = 8,
    parameter int          HOP_W     = $clog2(DIM_N + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [DIM_N:0]             rx_valid,
    input logic [DIM_N:0]             rx_ready,
    input logic [(DIM_N+1)*DIM_N-1:0] rx_dst,
    input logic [(DIM_N+1)*HOP_W-1:0] rx_hops,
    input logic [(DIM_N+1)*PAY_W-1:0] rx_data,
    input logic [DIM_N:0]             tx_valid,
    input logic [DIM_N:0]             tx_ready,
    input logic [(DIM_N+1)*DIM_N-1:0] tx_dst,
    input logic [(DIM_N+1)*HOP_W-1:0] tx_hops,
    input logic [(DIM_N+1)*PAY_W-1:0] tx_data
);
    localparam int               PORTS   = DIM_N + 1;
    localparam logic [DIM_N-1:0] MY_ADDR = DIM_N'(NODE_ADDR);

    generate
        for (genvar o = 0; o < PORTS; o++) begin : g_port
            // R4
            hop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid[o] |-> (int'(tx_hops[o*HOP_W +: HOP_W]) <= DIM_N));

            // R7
            stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[o] && !tx_ready[o]) |=>
                    (tx_valid[o] && $stable(tx_dst[o*DIM_N +: DIM_N])
                     && $stable(tx_hops[o*HOP_W +: HOP_W])
                     && $stable(tx_data[o*PAY_W +: PAY_W])));

            // R10
            ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rx_ready[o] |-> rx_valid[o]);

            // R8
            local_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rx_valid[o] && rx_ready[o] && (rx_dst[o*DIM_N +: DIM_N] == MY_ADDR))
                    |=> tx_valid[DIM_N]);
        end

        for (genvar d = 0; d < DIM_N; d++) begin : g_link
            localparam logic [DIM_N-1:0] UPTO = DIM_N'((64'd1 << (d + 1)) - 64'd1);
            localparam logic [DIM_N-1:0] SELF = DIM_N'(64'd1 << d);
            // R3
            link_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tx_valid[d] |-> (((tx_dst[d*DIM_N +: DIM_N] ^ MY_ADDR) & UPTO) == SELF));
        end
    endgenerate

    // R2
    local_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid[DIM_N] |-> (tx_dst[DIM_N*DIM_N +: DIM_N] == MY_ADDR));

endmodule

bind hcr_node_router hcr_node_router_chk #(
    .DIM_N     (DIM_N),
    .NODE_ADDR (NODE_ADDR),
    .PAY_W     (PAY_W),
    .HOP_W     (HOP_W)
) chk_i (.*);

// File: tb/hcr_node_router_tb_top.sv
// Bench for hcr_node_router: behavioural reference model compared every cycle,
// directed routing, contention and stall scenarios, then a randomized run.
module hcr_node_router_tb_top;
    localparam int DIM_N = 3;
    localparam int NODE  = 5;
    localparam int PAY_W = 8;
    localparam int HOP_W = 2;
    localparam int P     = DIM_N + 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [P-1:0]           rx_valid, rx_ready, tx_valid, tx_ready;
    logic [P*DIM_N-1:0]     rx_dst, tx_dst;
    logic [P*HOP_W-1:0]     rx_hops, tx_hops;
    logic [P*PAY_W-1:0]     rx_data, tx_data;

    int iv[P], id[P], ih[P], ip[P], ordy[P];      // driven stimulus
    int mv[P], md[P], mh[P], mp[P];               // model output registers
    int win[P], can[P], erdy[P];
    int vectors = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // Pack stimulus arrays onto the DUT pins.
    always_comb begin
        for (int i = 0; i < P; i++) begin
            rx_valid[i] = (iv[i] != 0);
            tx_ready[i] = (ordy[i] != 0);
            rx_dst[i*DIM_N +: DIM_N]  = DIM_N'(id[i]);
            rx_hops[i*HOP_W +: HOP_W] = HOP_W'(ih[i]);
            rx_data[i*PAY_W +: PAY_W] = PAY_W'(ip[i]);
        end
    end

    hcr_node_router #(.DIM_N(DIM_N), .NODE_ADDR(NODE), .PAY_W(PAY_W), .HOP_W(HOP_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_dst(rx_dst),
        .rx_hops(rx_hops), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dst(tx_dst),
        .tx_hops(tx_hops), .tx_data(tx_data));

    function automatic int route(int dst);
        int diff = (dst ^ NODE) & ((1 << DIM_N) - 1);
        if (diff == 0) return DIM_N;
        for (int d = 0; d < DIM_N; d++) if (diff[d]) return d;
        return DIM_N;
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model, then advance one clock.
    task automatic step();
        #1;
        for (int o = 0; o < P; o++) begin
            can[o] = (mv[o] == 0 || ordy[o] != 0) ? 1 : 0;
            win[o] = -1;
            for (int i = 0; i < P; i++)
                if (iv[i] != 0 && route(id[i]) == o && win[o] < 0) win[o] = i;
        end
        for (int i = 0; i < P; i++)
            erdy[i] = (iv[i] != 0 && win[route(id[i])] == i && can[route(id[i])] != 0) ? 1 : 0;
        for (int o = 0; o < P; o++) begin
            chk(o == DIM_N ? "R2" : "R3", int'(tx_valid[o]), mv[o], "tx_valid");
            if (mv[o] != 0) begin
                chk("R5", int'(tx_dst[o*DIM_N +: DIM_N]), md[o], "tx_dst");
                chk("R5", int'(tx_data[o*PAY_W +: PAY_W]), mp[o], "tx_data");
                chk("R4", int'(tx_hops[o*HOP_W +: HOP_W]), mh[o], "tx_hops");
            end
            chk("R6", int'(rx_ready[o]), erdy[o], "rx_ready");
        end
        @(posedge clk);
        for (int o = 0; o < P; o++) begin
            if (can[o] != 0) begin
                mv[o] = (win[o] >= 0) ? 1 : 0;
                if (win[o] >= 0) begin
                    md[o] = id[win[o]];
                    mp[o] = ip[win[o]];
                    mh[o] = ih[win[o]] + ((o < DIM_N) ? 1 : 0);
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        for (int i = 0; i < P; i++) begin iv[i] = 0; id[i] = 0; ih[i] = 0; ip[i] = 0; end
    endtask

    initial begin
        idle_inputs();
        for (int i = 0; i < P; i++) begin ordy[i] = 1; mv[i] = 0; md[i] = 0; mh[i] = 0; mp[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", int'(tx_valid), 0, "tx_valid in reset");
        rst_n = 1'b1;
        #1;
        chk("R1", int'(tx_valid), 0, "tx_valid after reset");

        // R2/R8: self-addressed message from link 0
        iv[0] = 1; id[0] = NODE; ih[0] = 2; ip[0] = 8'hAA;
        step();
        idle_inputs();
        chk("R8", int'(tx_valid[DIM_N]), 1, "local valid one edge after accept");
        chk("R2", int'(tx_hops[DIM_N*HOP_W +: HOP_W]), 2, "local hops unchanged");

        // R9/R10/R3/R4: two inputs to different links at once, input 0 idle
        iv[3] = 1; id[3] = 4; ih[3] = 0; ip[3] = 8'h11;   // diff 001 -> link 0
        iv[2] = 1; id[2] = 3; ih[2] = 1; ip[2] = 8'h22;   // diff 110 -> link 1
        #1;
        chk("R9", int'(rx_ready[3]) + int'(rx_ready[2]), 2, "concurrent accept");
        chk("R10", int'(rx_ready[0]), 0, "idle input ready");
        step();
        idle_inputs();
        chk("R3", int'(tx_valid[0]), 1, "link 0 used");
        chk("R3", int'(tx_valid[1]), 1, "link 1 used");
        chk("R4", int'(tx_hops[1*HOP_W +: HOP_W]), 2, "hop incremented");

        // R6: three inputs contend for link 0
        iv[1] = 1; id[1] = 4; ih[1] = 0; ip[1] = 8'h31;
        iv[2] = 1; id[2] = 6; ih[2] = 1; ip[2] = 8'h32;   // diff 011 -> link 0
        iv[3] = 1; id[3] = 0; ih[3] = 0; ip[3] = 8'h33;   // diff 101 -> link 0
        #1;
        chk("R6", int'(rx_ready[1]), 1, "lowest link wins");
        chk("R6", int'(rx_ready[2]), 0, "higher link loses");
        chk("R6", int'(rx_ready[3]), 0, "local input last");
        step();
        iv[1] = 0;
        step();
        iv[2] = 0;
        #1;
        chk("R6", int'(rx_ready[3]), 1, "local input served when alone");
        step();
        idle_inputs();
        step();

        // R7: stall on link 0
        ordy[0] = 0;
        iv[3] = 1; id[3] = 4; ih[3] = 0; ip[3] = 8'h5A;
        step();
        iv[3] = 0;
        iv[1] = 1; id[1] = 6; ih[1] = 1; ip[1] = 8'hC3;
        #1;
        chk("R7", int'(rx_ready[1]), 0, "blocked while stalled");
        step();
        chk("R7", int'(tx_data[0 +: PAY_W]), 8'h5A, "held payload");
        chk("R7", int'(tx_valid[0]), 1, "held valid");
        ordy[0] = 1;
        step();
        idle_inputs();
        step();
        step();

        // Randomized traffic with back-pressure; senders hold until accepted.
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < P; i++) begin
                if (!(iv[i] != 0 && erdy[i] == 0)) begin
                    iv[i] = ($urandom % 3 != 0) ? 1 : 0;
                    id[i] = $urandom % (1 << DIM_N);
                    ih[i] = $urandom % DIM_N;
                    ip[i] = $urandom % 256;
                end
                ordy[i] = ($urandom % 4 != 0) ? 1 : 0;
            end
            step();
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule